// File: doc/BRIEF.md
# Loadable Multiply-Accumulate Unit

This block is a pipelined multiply-accumulate engine. Each valid sample carries two 18-bit operands. Each operand has its own run-time flag that marks it as two's complement or unsigned. The product of a sample either replaces the contents of a 52-bit accumulator or is combined with the value the accumulator already holds. A per-sample load flag chooses between the two. Whether the product is added or subtracted is fixed by a parameter when the block is built and cannot change while it runs.

The operand and control inputs pass through an optional input register and then a full-precision multiplier. An optional pipeline register follows, and the accumulator itself acts as the output register. The load flag, the sign flags and the valid bit travel with the data through every stage. A change to any of them therefore takes effect on exactly the sample it came with. Cycles with no valid sample leave the accumulator untouched.

Top module: `mac_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `acc_out` is zero and `out_valid` is 0.
- R2: With `a_signed`=0 and `b_signed`=0 both operands are unsigned. For example, 0x3FFFF times 0x3FFFF gives 0xFFFF80001, a positive value.
- R3: A set sign flag makes its operand a two's-complement value (bit 17 is the sign bit). Each operand is treated independently, so signed-by-unsigned products are exact.
- R4: A valid sample with `load`=1 sets the accumulator to its own product, sign-extended to 52 bits, and discards the previous value.
- R5: With SUBTRACT=0, a valid sample with `load`=0 adds its product to the accumulator.
- R6: With SUBTRACT=1, a valid sample with `load`=0 subtracts its product from the accumulator.
- R7: When `in_valid`=0 the accumulator holds its value whatever `load` and the operands are, and the matching `out_valid` is 0.
- R8: The result of a sample appears on `acc_out`, with `out_valid`=1, exactly IN_REG+PIPE_REG+1 clock cycles after it is presented. With the default settings this is 3 cycles.
- R9: The sign and load flags are pipelined with their operands. Flags that change on every cycle are applied to their own sample only.
- R10: The accumulator arithmetic wraps modulo 2^52. For example, loading (-1)x1 and then adding 1x1 gives zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks a sample on the operand inputs |
| op_a | input | 18 | First operand |
| op_b | input | 18 | Second operand |
| a_signed | input | 1 | 1: op_a is two's complement; 0: unsigned |
| b_signed | input | 1 | 1: op_b is two's complement; 0: unsigned |
| load | input | 1 | 1: replace the accumulator with the product; 0: accumulate |
| out_valid | output | 1 | The accumulator was updated by a sample this cycle |
| acc_out | output | 52 | Accumulator value |

## Verification
A corrupted accumulator or a misaligned flag stays visible on `acc_out`. The error is carried forward by every following accumulate and is cleared only by the next load. A product that uses the wrong sign, or a load flag that lands on the wrong sample, shows up exactly IN_REG+PIPE_REG+1 cycles after the offending sample is presented. The bench therefore compares every cycle's output against a running arithmetic model. Corner operand values are swept against all four sign combinations, and the result is checked in both add and subtract builds.

// File: rtl/mac_pkg.sv
package mac_pkg;

  // Per-sample control bits carried alongside the operands.
  typedef struct packed {
    logic a_signed;
    logic b_signed;
    logic load;
  } mac_ctrl_t;

  localparam int unsigned CTRL_W = $bits(mac_ctrl_t);

  // Accumulator update selected for the current cycle.
  typedef enum logic [1:0] {
    ACC_HOLD = 2'd0,
    ACC_LOAD = 2'd1,
    ACC_ADD  = 2'd2,
    ACC_SUB  = 2'd3
  } acc_op_e;

endpackage

// File: rtl/mac_stage.sv
module mac_stage #(
  parameter int unsigned WIDTH  = 8,
  parameter bit          ENABLE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld_i,
  input  logic [WIDTH-1:0] data_i,
  output logic             vld_o,
  output logic [WIDTH-1:0] data_o
);

  generate
    if (ENABLE) begin : g_reg
      logic             vld_q;
      logic [WIDTH-1:0] data_q;
      logic [WIDTH-1:0] data_nxt;

      // Data only moves with a valid sample; the valid bit moves every cycle.
      always_comb begin
        data_nxt = data_q;
        if (vld_i) begin
          data_nxt = data_i;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q  <= 1'b0;
          data_q <= '0;
        end else begin
          vld_q  <= vld_i;
          data_q <= data_nxt;
        end
      end

      assign vld_o  = vld_q;
      assign data_o = data_q;
    end else begin : g_bypass
      assign vld_o  = vld_i;
      assign data_o = data_i;
    end
  endgenerate

endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int unsigned A_W = 18,
  parameter int unsigned B_W = 18,
  localparam int unsigned PROD_W = A_W + B_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [A_W-1:0]           a_i,
  input  logic [B_W-1:0]           b_i,
  input  logic                     a_signed_i,
  input  logic                     b_signed_i,
  output logic signed [PROD_W-1:0] prod_o
);

  logic signed [A_W:0] a_ext;
  logic signed [B_W:0] b_ext;

  // One extra bit per operand: the sign bit for signed, zero for unsigned.
  always_comb begin
    a_ext  = {a_signed_i & a_i[A_W-1], a_i};
    b_ext  = {b_signed_i & b_i[B_W-1], b_i};
    prod_o = PROD_W'(a_ext) * PROD_W'(b_ext);
  end

  // R2: an unsigned-by-unsigned product is never negative
  assert_unsigned_nonneg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_signed_i && !b_signed_i) |-> !prod_o[PROD_W-1]);

  // R3: two negative signed operands give a strictly positive product
  assert_neg_by_neg_positive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (a_signed_i && a_i[A_W-1] && b_signed_i && b_i[B_W-1]) |-> (prod_o > 0));

endmodule

// File: rtl/mac_accum.sv
module mac_accum
  import mac_pkg::*;
#(
  parameter int unsigned PROD_W   = 38,
  parameter int unsigned ACC_W    = 52,
  parameter bit          SUBTRACT = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     vld_i,
  input  logic                     load_i,
  input  logic signed [PROD_W-1:0] prod_i,
  output logic                     vld_o,
  output logic [ACC_W-1:0]         acc_o
);

  localparam int unsigned EXT_W = ACC_W - PROD_W;

  acc_op_e          acc_op;
  logic [ACC_W-1:0] prod_ext;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_nxt;
  logic             acc_en;
  logic             vld_q;

  always_comb begin
    prod_ext = {{EXT_W{prod_i[PROD_W-1]}}, prod_i};
    acc_op   = ACC_HOLD;
    if (vld_i) begin
      if (load_i) begin
        acc_op = ACC_LOAD;
      end else if (SUBTRACT) begin
        acc_op = ACC_SUB;
      end else begin
        acc_op = ACC_ADD;
      end
    end
  end

  always_comb begin
    acc_en = (acc_op != ACC_HOLD);
    unique case (acc_op)
      ACC_LOAD: acc_nxt = prod_ext;
      ACC_ADD:  acc_nxt = acc_q + prod_ext;
      ACC_SUB:  acc_nxt = acc_q - prod_ext;
      default:  acc_nxt = acc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_i;
      if (acc_en) begin
        acc_q <= acc_nxt;
      end
    end
  end

  assign acc_o = acc_q;
  assign vld_o = vld_q;

  // R7: an idle cycle leaves the accumulator untouched
  assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> $stable(acc_q));

  // R4: a load discards history and keeps only the sign-extended product
  assert_load_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && load_i) |=> (acc_q == $past(prod_ext)));

  // R8: out_valid follows the valid bit reaching the accumulator
  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |=> vld_o);

endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int unsigned A_W      = 18,
  parameter int unsigned B_W      = 18,
  parameter int unsigned ACC_W    = 52,
  parameter bit          IN_REG   = 1'b1,
  parameter bit          PIPE_REG = 1'b1,
  parameter bit          SUBTRACT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [A_W-1:0]   op_a,
  input  logic [B_W-1:0]   op_b,
  input  logic             a_signed,
  input  logic             b_signed,
  input  logic             load,
  output logic             out_valid,
  output logic [ACC_W-1:0] acc_out
);

  localparam int unsigned PROD_W = A_W + B_W + 2;
  localparam int unsigned S1_W   = A_W + B_W + CTRL_W;
  localparam int unsigned S2_W   = PROD_W + 1;

  // Stage 1: operands and controls
  mac_ctrl_t          in_ctrl;
  mac_ctrl_t          s1_ctrl;
  logic [S1_W-1:0]    s1_d;
  logic [S1_W-1:0]    s1_q;
  logic               s1_vld;
  logic [A_W-1:0]     s1_a;
  logic [B_W-1:0]     s1_b;

  always_comb begin
    in_ctrl.a_signed = a_signed;
    in_ctrl.b_signed = b_signed;
    in_ctrl.load     = load;
    s1_d             = {in_ctrl, op_a, op_b};
  end

  mac_stage #(.WIDTH(S1_W), .ENABLE(IN_REG)) u_in_stage (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld_i  (in_valid),
    .data_i (s1_d),
    .vld_o  (s1_vld),
    .data_o (s1_q)
  );

  assign {s1_ctrl, s1_a, s1_b} = s1_q;

  // Multiplier
  logic signed [PROD_W-1:0] s1_prod;

  mac_mult #(.A_W(A_W), .B_W(B_W)) u_mult (
    .clk        (clk),
    .rst_n      (rst_n),
    .a_i        (s1_a),
    .b_i        (s1_b),
    .a_signed_i (s1_ctrl.a_signed),
    .b_signed_i (s1_ctrl.b_signed),
    .prod_o     (s1_prod)
  );

  // Stage 2: product plus load flag
  logic [S2_W-1:0]          s2_q;
  logic                     s2_vld;
  logic                     s2_load;
  logic signed [PROD_W-1:0] s2_prod;

  mac_stage #(.WIDTH(S2_W), .ENABLE(PIPE_REG)) u_pipe_stage (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld_i  (s1_vld),
    .data_i ({s1_ctrl.load, s1_prod}),
    .vld_o  (s2_vld),
    .data_o (s2_q)
  );

  assign s2_load = s2_q[S2_W-1];
  assign s2_prod = s2_q[PROD_W-1:0];

  // Accumulator, which also serves as the output register
  mac_accum #(.PROD_W(PROD_W), .ACC_W(ACC_W), .SUBTRACT(SUBTRACT)) u_accum (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld_i  (s2_vld),
    .load_i (s2_load),
    .prod_i (s2_prod),
    .vld_o  (out_valid),
    .acc_o  (acc_out)
  );

  // R1: nothing is reported valid while the pipeline is empty after reset
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && acc_out == '0));

endmodule

// File: tb/tb_mac_unit.sv
module tb_mac_unit;

  localparam int LAT = 3;
  localparam int DEPTH = 4096;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [17:0] op_a;
  logic [17:0] op_b;
  logic        a_signed;
  logic        b_signed;
  logic        load;
  logic        out_valid;
  logic        out_valid_s;
  logic [51:0] acc_out;
  logic [51:0] acc_out_s;

  mac_unit #(.SUBTRACT(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .a_signed(a_signed), .b_signed(b_signed), .load(load),
    .out_valid(out_valid), .acc_out(acc_out)
  );

  mac_unit #(.SUBTRACT(1'b1)) dut_sub (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .a_signed(a_signed), .b_signed(b_signed), .load(load),
    .out_valid(out_valid_s), .acc_out(acc_out_s)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int t = 0;
  bit done = 0;

  logic [51:0] ref_add = '0;
  logic [51:0] ref_sub = '0;
  logic [51:0] exp_add [DEPTH];
  logic [51:0] exp_sub [DEPTH];
  logic        exp_v   [DEPTH];
  string       tag     [DEPTH];

  task automatic chk(input string req, input logic [51:0] act, input logic [51:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic step(input logic [17:0] a, input logic [17:0] b, input logic as_,
                      input logic bs_, input logic ld, input logic v, input string tg);
    longint pa;
    longint pb;
    logic [51:0] p;
    int k;
    @(negedge clk);
    if (t >= LAT) begin
      k = (t - LAT) % DEPTH;
      chk({tag[k], " add-build"}, acc_out, exp_add[k]);
      chk({tag[k], " R6 sub-build"}, acc_out_s, exp_sub[k]);
      chk({tag[k], " R8 out_valid"}, {51'd0, out_valid}, {51'd0, exp_v[k]});
      chk({tag[k], " R8 out_valid sub"}, {51'd0, out_valid_s}, {51'd0, exp_v[k]});
    end
    if (v) begin
      pa = as_ ? longint'($signed(a)) : longint'(a);
      pb = bs_ ? longint'($signed(b)) : longint'(b);
      p = 52'(pa * pb);
      ref_add = ld ? p : ref_add + p;
      ref_sub = ld ? p : ref_sub - p;
    end
    k = t % DEPTH;
    exp_add[k] = ref_add;
    exp_sub[k] = ref_sub;
    exp_v[k]   = v;
    tag[k]     = tg;
    op_a = a; op_b = b; a_signed = as_; b_signed = bs_; load = ld; in_valid = v;
    t++;
  endtask

  logic [17:0] corner [8];

  initial begin
    corner[0] = 18'h00000; corner[1] = 18'h00001; corner[2] = 18'h00002;
    corner[3] = 18'h1FFFF; corner[4] = 18'h20000; corner[5] = 18'h20001;
    corner[6] = 18'h3FFFE; corner[7] = 18'h3FFFF;
    rst_n = 1'b0; in_valid = 0; op_a = '0; op_b = '0;
    a_signed = 0; b_signed = 0; load = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset acc", acc_out, '0);
    chk("R1 reset valid", {51'd0, out_valid}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release acc", acc_out, '0);
    chk("R1 after release valid", {51'd0, out_valid}, '0);

    // Specific unsigned and wrap cases
    step(18'h3FFFF, 18'h3FFFF, 0, 0, 1, 1, "R2 unsigned max");
    step(18'h3FFFF, 18'h00001, 1, 0, 1, 1, "R10 load negative");
    step(18'h00001, 18'h00001, 0, 0, 0, 1, "R10 wrap to zero");

    // Corner sweep over all sign combinations, flags changing every cycle
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        for (int s = 0; s < 4; s++) begin
          step(corner[i], corner[j], s[1], s[0], (j == 0 && s == 0), 1,
               (j == 0 && s == 0) ? "R4 load" :
               (s == 0) ? "R2 unsigned" : (s == 3) ? "R3 signed" : "R9 mixed signs");
        end
      end
    end

    // Back-to-back loads
    for (int n = 0; n < 20; n++) begin
      step(18'($urandom), 18'($urandom), 1'($urandom), 1'($urandom), 1, 1, "R4 back-to-back load");
    end

    // Idle cycles with load asserted must not touch the accumulator
    step(18'h12345, 18'h00777, 1, 1, 1, 1, "R4 load before idle");
    for (int n = 0; n < 6; n++) begin
      step(18'h3FFFF, 18'h3FFFF, 1, 1, 1, 0, "R7 idle with load");
    end
    step(18'h00003, 18'h00005, 0, 0, 0, 1, "R5 accumulate after idle");

    // Random mixes
    for (int n = 0; n < 1500; n++) begin
      step(18'($urandom), 18'($urandom), 1'($urandom), 1'($urandom),
           ($urandom % 10) == 0, ($urandom % 4) != 0, "R5 random accumulate");
    end

    // Flush
    for (int n = 0; n < LAT + 2; n++) begin
      step('0, '0, 0, 0, 0, 0, "R7 flush");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule